// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides where each processor memory access goes while system-management memory is being protected. It keeps three small configuration registers: a main SMRAM control byte, an extended control byte and a 16-bit extended TSEG size word. All three are written together through one 32-bit configuration write with four byte enables. Each register has its own write mask, and that mask shrinks once software sets the lock bit.

For every access the block takes a physical address, a flag that marks the access as coming from system-management mode (SMM), and an access length. From these it returns a route code. The possible routes are:
- ordinary DRAM;
- PCI or legacy video;
- SMRAM backed by DRAM;
- a blackhole that reads as all ones and swallows writes;
- the relocated high SMRAM alias.

The TSEG carve-out sits just below the top of low memory. Its size comes from a two-bit select field, or from an elaboration-time megabyte count. That count can also be read back through a query handshake on the size word.

Top module: `smt_top`

## Requirements
- R1: After reset the configuration read word is {size word, extended control, main control}. Main control reads 0x02 and extended control reads 0x00. The size word reads 0xFFFF when the configured megabyte count is nonzero, and 0x0000 otherwise.
- R2: Byte lane 0 writes main control, lane 1 writes extended control, and lanes 2 and 3 write the low and high bytes of the size word. Before lock:
  - main control bits 6 (open), 5, 4 (lock) and 3 (global enable) are writable, and bits 2:0 hold 010;
  - extended control bits 7 (high enable), 2:1 (TSEG select) and 0 (TSEG enable) are writable, and the other bits read 0.
- R3: A write that sets lock (bit 4) clears open (bit 6) in the same write. From then on only bit 5 of main control is writable, lock stays set, open can never be set, and extended control is frozen. Only reset restores the full masks.
- R4: Route codes are 0 DRAM, 1 PCI/video, 2 SMRAM, 3 blackhole, 4 high alias. For a non-SMM access, the low window 0xA0000–0xBFFFF goes to SMRAM (2) only when open is set and high enable is clear, and otherwise to PCI (1). The high window 0xFEDA0000–0xFEDBFFFF goes to the high alias (4) only when open and high enable are both set.
- R5: For an SMM access with global enable set, high enable clear selects SMRAM (2) in the low window, and high enable set selects the high alias (4) in the high window. With global enable clear, SMM accesses are routed as non-SMM ones.
- R6: TSEG select values 0, 1, 2 and 3 give sizes of 1 MB, 2 MB, 8 MB and the configured megabyte count. The size is zero whenever TSEG enable is clear.
- R7: Addresses in [top − size, top) go to the blackhole (3) when the access is non-SMM and to SMRAM (2) when it is SMM. This rule takes priority over every other rule.
- R8: The blackhole read data has all ones in the lowest N bytes for an access length N of 1 to 4, and is zero for any other length or any other route.
- R9: A size-word write whose merged result is 0xFFFF stores the configured megabyte count instead, provided that count is nonzero. Any other merged value is stored as written.
- R10: Addresses outside every window above go to DRAM (0) below the top of low memory, and to PCI (1) at or above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgByteEn | input | 4 | Byte enables of the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Current register contents |
| accAddr | input | ADDR_W | Physical address of the access |
| accSmm | input | 1 | Access is issued in SMM |
| accLen | input | 3 | Access length in bytes |
| accRoute | output | 3 | Route code |
| accHoleData | output | 32 | Blackhole read data |

## Verification
The route checks assume the address, SMM flag and length are steady for the whole cycle in which the route is sampled. They also assume that configuration writes do not change while an access is being classified. The stimulus follows both rules: it changes access inputs and write strobes only on the falling clock edge, and it samples the combinational route only after all inputs have settled. The lock checks rely on the main and extended control bytes being written in the same write or in separate writes. The sequences are chosen so that lock is set only after the full-mask sweep has finished.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [2:0] {
    ROUTE_DRAM  = 3'd0,
    ROUTE_PCI   = 3'd1,
    ROUTE_SMRAM = 3'd2,
    ROUTE_HOLE  = 3'd3,
    ROUTE_HIGH  = 3'd4
  } route_e;

  typedef struct packed {
    logic ctlWe;
    logic extCtlWe;
    logic sizeLoWe;
    logic sizeHiWe;
  } cfg_strobe_t;

  typedef struct packed {
    logic dOpen;
    logic gEn;
    logic hiEn;
    logic tEn;
  } smm_view_t;

  localparam int OPEN_BIT   = 6;
  localparam int LOCK_BIT   = 4;
  localparam int GLOBAL_BIT = 3;
  localparam int HIGH_BIT   = 7;
  localparam int TSEL_LO    = 1;
  localparam int TEN_BIT    = 0;

  localparam logic [7:0]  CTL_RESET      = 8'h02;
  localparam logic [7:0]  EXT_CTL_RESET  = 8'h00;
  localparam logic [7:0]  CTL_MASK_OPEN  = 8'h78;
  localparam logic [7:0]  CTL_MASK_LOCK  = 8'h20;
  localparam logic [7:0]  EXT_MASK_OPEN  = 8'h87;
  localparam logic [7:0]  EXT_MASK_LOCK  = 8'h00;
  localparam logic [15:0] SIZE_QUERY     = 16'hFFFF;
endpackage

// File: rtl/smt_ctrl.sv
module smt_ctrl
  import smt_pkg::*;
(
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgByteEn,
  output cfg_strobe_t strobe
);
  always_comb begin
    strobe.ctlWe    = cfgWrEn & cfgByteEn[0];
    strobe.extCtlWe = cfgWrEn & cfgByteEn[1];
    strobe.sizeLoWe = cfgWrEn & cfgByteEn[2];
    strobe.sizeHiWe = cfgWrEn & cfgByteEn[3];
  end
endmodule

// File: rtl/smt_regs.sv
module smt_regs
  import smt_pkg::*;
#(
  parameter int EXT_TSEG_MB = 16,
  parameter int MB_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_strobe_t      strobe,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  output smm_view_t        view,
  output logic [MB_W-1:0]  tsegMb
);
  localparam logic [15:0] EXT_WORD   = 16'(EXT_TSEG_MB);
  localparam logic [15:0] SIZE_RESET = (EXT_TSEG_MB > 0) ? SIZE_QUERY : 16'h0000;

  logic [7:0]  ctlReg, extCtlReg, ctlNext, extNext, ctlMask, extMask;
  logic [15:0] sizeReg, sizeNext, sizeMerged;
  logic        locked;

  assign locked  = ctlReg[LOCK_BIT];
  assign ctlMask = locked ? CTL_MASK_LOCK : CTL_MASK_OPEN;
  assign extMask = locked ? EXT_MASK_LOCK : EXT_MASK_OPEN;

  always_comb begin
    ctlNext = ctlReg;
    if (strobe.ctlWe) ctlNext = (ctlReg & ~ctlMask) | (cfgWrData[7:0] & ctlMask);
    if (ctlNext[LOCK_BIT]) ctlNext[OPEN_BIT] = 1'b0;
  end

  always_comb begin
    extNext = extCtlReg;
    if (strobe.extCtlWe) extNext = (extCtlReg & ~extMask) | (cfgWrData[15:8] & extMask);
  end

  always_comb begin
    sizeMerged[7:0]  = strobe.sizeLoWe ? cfgWrData[23:16] : sizeReg[7:0];
    sizeMerged[15:8] = strobe.sizeHiWe ? cfgWrData[31:24] : sizeReg[15:8];
    sizeNext = sizeMerged;
    if ((strobe.sizeLoWe || strobe.sizeHiWe) && (EXT_TSEG_MB > 0)
        && (sizeMerged == SIZE_QUERY))
      sizeNext = EXT_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg    <= CTL_RESET;
      extCtlReg <= EXT_CTL_RESET;
      sizeReg   <= SIZE_RESET;
    end else begin
      ctlReg    <= ctlNext;
      extCtlReg <= extNext;
      sizeReg   <= sizeNext;
    end
  end

  assign cfgRdData = {sizeReg, extCtlReg, ctlReg};

  always_comb begin
    view.dOpen = ctlReg[OPEN_BIT];
    view.gEn   = ctlReg[GLOBAL_BIT];
    view.hiEn  = extCtlReg[HIGH_BIT];
    view.tEn   = extCtlReg[TEN_BIT];
  end

  always_comb begin
    unique case (extCtlReg[TSEL_LO +: 2])
      2'd0:    tsegMb = MB_W'(1);
      2'd1:    tsegMb = MB_W'(2);
      2'd2:    tsegMb = MB_W'(8);
      default: tsegMb = MB_W'(EXT_TSEG_MB);
    endcase
    if (!extCtlReg[TEN_BIT]) tsegMb = '0;
  end

  assert_lock_closes_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[LOCK_BIT] |-> !ctlReg[OPEN_BIT]);

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlReg[LOCK_BIT]) |-> ctlReg[LOCK_BIT]);

  assert_ext_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlReg[LOCK_BIT]) |-> $stable(extCtlReg));

  generate
    if (EXT_TSEG_MB > 0) begin : g_query
      assert_query_answered_R9: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.sizeLoWe || strobe.sizeHiWe) |=> (sizeReg != SIZE_QUERY));
    end
  endgenerate
endmodule

// File: rtl/smt_route.sv
module smt_route
  import smt_pkg::*;
#(
  parameter int              ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP = 32'h4000_0000,
  parameter int              MB_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  input  logic [2:0]        accLen,
  input  smm_view_t         view,
  input  logic [MB_W-1:0]   tsegMb,
  output route_e            route,
  output logic [31:0]       holeData
);
  localparam logic [ADDR_W-1:0] LOW_WIN_BASE  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] LOW_WIN_LAST  = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] HIGH_WIN_BASE = ADDR_W'(32'hFEDA_0000);
  localparam logic [ADDR_W-1:0] HIGH_WIN_LAST = ADDR_W'(32'hFEDB_FFFF);

  logic [ADDR_W-1:0] tsegBytes, tsegBase;
  logic inLow, inHigh, inTseg, lenOk;

  assign tsegBytes = ADDR_W'(tsegMb) << 20;
  assign tsegBase  = LOW_TOP - tsegBytes;
  assign inLow  = (accAddr >= LOW_WIN_BASE) && (accAddr <= LOW_WIN_LAST);
  assign inHigh = (accAddr >= HIGH_WIN_BASE) && (accAddr <= HIGH_WIN_LAST);
  assign inTseg = (tsegMb != '0) && (accAddr >= tsegBase) && (accAddr < LOW_TOP);

  always_comb begin
    route = (accAddr < LOW_TOP) ? ROUTE_DRAM : ROUTE_PCI;
    if (inHigh && view.dOpen && view.hiEn) route = ROUTE_HIGH;
    if (inLow) route = (view.dOpen && !view.hiEn) ? ROUTE_SMRAM : ROUTE_PCI;
    if (accSmm && view.gEn) begin
      if (inLow && !view.hiEn) route = ROUTE_SMRAM;
      if (inHigh && view.hiEn) route = ROUTE_HIGH;
    end
    if (inTseg) route = accSmm ? ROUTE_SMRAM : ROUTE_HOLE;
  end

  assign lenOk = (accLen >= 3'd1) && (accLen <= 3'd4);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign holeData[8*b +: 8] =
        ((route == ROUTE_HOLE) && lenOk && (accLen > 3'(b))) ? 8'hFF : 8'h00;
    end
  endgenerate

  assert_hole_not_smm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (route == ROUTE_HOLE) |-> !accSmm);

  assert_no_hole_untseg_R6: assert property (@(posedge clk) disable iff (!rstN)
    !view.tEn |-> (route != ROUTE_HOLE));

  assert_high_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (route == ROUTE_HIGH && !accSmm) |-> (view.dOpen && view.hiEn));

  assert_smm_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (route == ROUTE_HIGH) |-> view.hiEn);

  assert_hole_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (route != ROUTE_HOLE) |-> (holeData == 32'h0));
endmodule

// File: rtl/smt_top.sv
module smt_top
  import smt_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP       = 32'h4000_0000,
  parameter int                EXT_TSEG_MB   = 16,
  parameter int                EXT_TSEG_MAX  = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  input  logic [2:0]        accLen,
  output logic [2:0]        accRoute,
  output logic [31:0]       accHoleData
);
  localparam int MB_RAW = $clog2(EXT_TSEG_MAX + 1);
  localparam int MB_W   = (MB_RAW < 4) ? 4 : MB_RAW;

  generate
    if (EXT_TSEG_MB > EXT_TSEG_MAX || EXT_TSEG_MB < 0) begin : g_bad_size
      $error("extended TSEG megabyte count out of range");
    end
    if (ADDR_W < 32) begin : g_bad_width
      $error("address width must cover the high SMRAM alias");
    end
  endgenerate

  cfg_strobe_t      strobe;
  smm_view_t        view;
  logic [MB_W-1:0]  tsegMb;
  route_e           route;

  smt_ctrl u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgByteEn(cfgByteEn),
    .strobe   (strobe)
  );

  smt_regs #(.EXT_TSEG_MB(EXT_TSEG_MB), .MB_W(MB_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .view     (view),
    .tsegMb   (tsegMb)
  );

  smt_route #(.ADDR_W(ADDR_W), .LOW_TOP(LOW_TOP), .MB_W(MB_W)) u_route (
    .clk     (clk),
    .rstN    (rstN),
    .accAddr (accAddr),
    .accSmm  (accSmm),
    .accLen  (accLen),
    .view    (view),
    .tsegMb  (tsegMb),
    .route   (route),
    .holeData(accHoleData)
  );

  assign accRoute = route;
endmodule

// File: tb/sim_smt_top.sv
module sim_smt_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TOP        = 32'h4000_0000;
  localparam int          EXT_MB     = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic [31:0] accAddr = 32'h0;
  logic        accSmm = 1'b0;
  logic [2:0]  accLen = 3'd4;
  logic [2:0]  accRoute;
  logic [31:0] accHoleData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  smt_top #(.ADDR_W(32), .LOW_TOP(TOP), .EXT_TSEG_MB(EXT_MB), .EXT_TSEG_MAX(4095)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .accAddr(accAddr),
    .accSmm(accSmm), .accLen(accLen), .accRoute(accRoute), .accHoleData(accHoleData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    #1;
  endtask

  function automatic int expRoute(input logic [31:0] a, input bit smm, input bit op,
                                  input bit g, input bit h, input bit ten, input int tsz);
    longint sz, base;
    bit inLow, inHigh;
    int r;
    sz = 0;
    if (ten) sz = (tsz == 0) ? 1 : (tsz == 1) ? 2 : (tsz == 2) ? 8 : EXT_MB;
    sz = sz * 1048576;
    base = longint'(TOP) - sz;
    if (sz != 0 && longint'(a) >= base && longint'(a) < longint'(TOP)) return smm ? 2 : 3;
    inLow  = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    inHigh = (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
    if (smm && g) begin
      if (inLow && !h) return 2;
      if (inHigh && h) return 4;
    end
    if (inLow) return (op && !h) ? 2 : 1;
    if (inHigh && op && h) return 4;
    r = (a < TOP) ? 0 : 1;
    return r;
  endfunction

  function automatic logic [31:0] probe(input int i, input longint base);
    case (i)
      0: return 32'h0;
      1: return 32'h0009_FFFF;
      2: return 32'h000A_0000;
      3: return 32'h000B_FFFF;
      4: return 32'h000C_0000;
      5: return 32'hFEDA_0000;
      6: return 32'hFEDB_FFFF;
      7: return 32'hFEDC_0000;
      8: return 32'(base - 1);
      9: return 32'(base);
      10: return TOP - 1;
      default: return TOP;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    doReset();
    // R1 reset contents
    check(cfgRdData == 32'hFFFF_0002, "R1 reset readback", cfgRdData, 32'hFFFF_0002);

    // R2 masks before lock
    cfgWrite(4'b0011, 32'h0000_FFEF);
    check(cfgRdData[15:0] == 16'h876A, "R2 writable bits", {16'h0, cfgRdData[15:0]}, 32'h876A);
    cfgWrite(4'b0001, 32'h0000_0000);
    check(cfgRdData[15:0] == 16'h8702, "R2 byte lane isolation", {16'h0, cfgRdData[15:0]}, 32'h8702);

    // R4 R5 R6 R7 R10 sweep over all control combinations
    for (int c = 0; c < 64; c++) begin
      bit op, g, h, ten; int tsz; longint sz, base;
      logic [7:0] ctl, ext;
      op = c[0]; g = c[1]; h = c[2]; ten = c[3]; tsz = (c >> 4) & 3;
      ctl = 8'h02 | (8'(op) << 6) | (8'(g) << 3);
      ext = (8'(h) << 7) | (8'(tsz) << 1) | 8'(ten);
      cfgWrite(4'b0011, {16'h0, ext, ctl});
      check(cfgRdData[15:0] == {ext, ctl}, "R2 sweep readback", {16'h0, cfgRdData[15:0]}, {16'h0, ext, ctl});
      sz = 0;
      if (ten) sz = (tsz == 0) ? 1 : (tsz == 1) ? 2 : (tsz == 2) ? 8 : EXT_MB;
      base = longint'(TOP) - sz * 1048576;
      for (int i = 0; i < 12; i++) begin
        for (int s = 0; s < 2; s++) begin
          int e;
          accAddr = probe(i, base); accSmm = s[0]; accLen = 3'd4;
          #1;
          e = expRoute(accAddr, s[0], op, g, h, ten, tsz);
          check(int'(accRoute) == e, "R4/R5/R6/R7/R10 route", {29'h0, accRoute}, 32'(e));
        end
      end
    end

    // R8 blackhole data across lengths (TSEG enabled, 1 MB)
    cfgWrite(4'b0011, 32'h0000_0102);
    for (int l = 0; l < 8; l++) begin
      logic [31:0] e;
      accAddr = TOP - 4; accSmm = 1'b0; accLen = 3'(l);
      #1;
      e = (l >= 1 && l <= 4) ? ((l == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*l)) - 1)) : 32'h0;
      check(accHoleData == e, "R8 hole data", accHoleData, e);
    end
    accSmm = 1'b1; accLen = 3'd4; #1;
    check(accHoleData == 32'h0, "R8 no data for SMM", accHoleData, 32'h0);

    // R9 size query handshake
    cfgWrite(4'b1100, 32'h1234_0000);
    check(cfgRdData[31:16] == 16'h1234, "R9 plain store", {16'h0, cfgRdData[31:16]}, 32'h1234);
    cfgWrite(4'b1000, 32'hFF00_0000);
    check(cfgRdData[31:16] == 16'hFF34, "R9 high byte only", {16'h0, cfgRdData[31:16]}, 32'hFF34);
    cfgWrite(4'b0100, 32'h00FF_0000);
    check(cfgRdData[31:16] == 16'(EXT_MB), "R9 merged query", {16'h0, cfgRdData[31:16]}, 32'(EXT_MB));
    cfgWrite(4'b1100, 32'hFFFF_0000);
    check(cfgRdData[31:16] == 16'(EXT_MB), "R9 full query", {16'h0, cfgRdData[31:16]}, 32'(EXT_MB));

    // R3 lock behaviour
    cfgWrite(4'b0011, 32'h0000_0002);
    cfgWrite(4'b0001, 32'h0000_0058);
    check(cfgRdData[7:0] == 8'h1A, "R3 lock clears open", {24'h0, cfgRdData[7:0]}, 32'h1A);
    cfgWrite(4'b0001, 32'h0000_0040);
    check(cfgRdData[7:0] == 8'h1A, "R3 open blocked", {24'h0, cfgRdData[7:0]}, 32'h1A);
    cfgWrite(4'b0010, 32'h0000_8100);
    check(cfgRdData[15:8] == 8'h00, "R3 ext frozen", {24'h0, cfgRdData[15:8]}, 32'h0);
    cfgWrite(4'b0001, 32'h0000_0020);
    check(cfgRdData[7:0] == 8'h3A, "R3 bit5 still writable", {24'h0, cfgRdData[7:0]}, 32'h3A);
    accAddr = 32'h000A_0000; accSmm = 1'b0; accLen = 3'd4; #1;
    check(accRoute == 3'd1, "R4 locked low window non-SMM", {29'h0, accRoute}, 32'd1);
    accSmm = 1'b1; #1;
    check(accRoute == 3'd2, "R5 locked low window SMM", {29'h0, accRoute}, 32'd2);

    // R3 reset restores full masks, R1 again
    doReset();
    check(cfgRdData == 32'hFFFF_0002, "R1 second reset", cfgRdData, 32'hFFFF_0002);
    cfgWrite(4'b0011, 32'h0000_8148);
    check(cfgRdData[15:0] == 16'h814A, "R3 masks restored", {16'h0, cfgRdData[15:0]}, 32'h814A);
    accAddr = 32'hFEDA_0000; accSmm = 1'b0; #1;
    check(accRoute == 3'd4, "R4 high alias open", {29'h0, accRoute}, 32'd4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule